// File: doc/BRIEF.md
# Legacy VGA Address Forwarding Decoder

This block sits on the upstream side of a two-port bus bridge and inspects each transaction offered to it. It decides whether the transaction lands in the legacy display windows and must cross to the downstream bus. There are two such windows: the display memory window, and the small register windows in I/O space. For each transaction it reports four things: whether to forward it, whether the bridge claims it, whether a read must go out as a single non-prefetchable data phase, and which byte enables travel with it.

Two control bits select the behaviour. The display-enable bit opens both memory and I/O windows. The palette-snoop bit opens only the palette write registers, and only when display-enable is clear. I/O decoding uses the 10-bit legacy alias rule. Bits above the alias field and below bit 16 are ignored, and every higher bit must be zero. Every result appears on registered outputs one clock after the valid strobe.

Top module: `vga_fwd_decoder`

## Requirements
- R1: While rst_n is low, fwd_o, claim_o and single_o are 0 and be_o is all zeros.
- R2: Commands are encoded as txn_cmd 00 memory read, 01 memory write, 10 I/O read, 11 I/O write. With vga_en=1, a memory command whose address lies in 000A_0000h..000B_FFFFh inclusive is forwarded. Memory addresses 0009_FFFFh and 000C_0000h (start of the BIOS area) are not forwarded.
- R3: A forwarded memory read raises single_o. A forwarded write or I/O access leaves single_o at 0. be_o equals the strobed txn_be when forwarded and is all zeros otherwise.
- R4: With vga_en=1, an I/O command is forwarded when address bits [9:0] lie in 3B0h..3BBh or 3C0h..3DFh. Values 3AFh, 3BCh, 3BFh and 3E0h are not forwarded.
- R5: Address bits [15:10] of an I/O command do not affect the decision, so each I/O window repeats every 1 KB.
- R6: An I/O command whose address bits [31:16] are not all zero is never forwarded.
- R7: With snoop_en=1 and vga_en=0, only I/O writes whose bits [9:0] are 3C6h, 3C8h or 3C9h are forwarded, and under the R6 rule. I/O reads to those addresses, and all other addresses, are not forwarded. claim_o equals fwd_o for every transaction.
- R8: With vga_en=1 and snoop_en=1, the outputs are identical to those with vga_en=1 alone.
- R9: With vga_en=0 and snoop_en=0, nothing is forwarded or claimed.
- R10: A memory command never matches the I/O windows, and an I/O command never matches the memory window.
- R11: Outputs reflect the transaction strobed on the previous rising clock edge. In a cycle after txn_valid was low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| txn_valid | input | 1 | Transaction strobe |
| txn_cmd | input | 2 | Command type (00 mem rd, 01 mem wr, 10 io rd, 11 io wr) |
| txn_addr | input | 32 | Transaction address |
| txn_be | input | 4 | Byte enables of the transaction |
| vga_en | input | 1 | Display-enable control |
| snoop_en | input | 1 | Palette-snoop control |
| fwd_o | output | 1 | Forward downstream |
| claim_o | output | 1 | Bridge claims the transaction |
| single_o | output | 1 | Non-prefetchable single-phase read |
| be_o | output | 4 | Byte enables passed downstream |

## Verification
The bench builds the block with its default parameters: 32 address bits, 4 byte enables, a 10-bit alias field and a 16-bit I/O space. With these values every upper-address bit above bit 16 can be made nonzero, so the R6 rule is exercised across the whole field. The alias bits [15:10] are varied over all 64 patterns for the R5 rule. Random addresses are biased toward the window edges, and all four control-bit combinations are applied to each command type.

// File: rtl/vga_fwd_pkg.sv
package vga_fwd_pkg;
  typedef enum logic [1:0] {
    CMD_MEM_RD = 2'b00,
    CMD_MEM_WR = 2'b01,
    CMD_IO_RD  = 2'b10,
    CMD_IO_WR  = 2'b11
  } vga_cmd_e;

  typedef struct packed {
    logic fwd;
    logic single;
  } vga_decision_t;

  function automatic logic is_io_cmd(input logic [1:0] cmd);
    return cmd[1];
  endfunction
endpackage

// File: rtl/vga_mem_match.sv
module vga_mem_match #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_LO = ADDR_W'(32'h000A_0000),
  parameter logic [ADDR_W-1:0] WIN_HI = ADDR_W'(32'h000B_FFFF)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic above_lo;
  logic below_hi;

  always_comb begin
    above_lo = (addr >= WIN_LO);
    below_hi = (addr <= WIN_HI);
    hit      = above_lo & below_hi;
  end
endmodule

// File: rtl/vga_io_match.sv
module vga_io_match #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ALIAS_W = 10,
  parameter int unsigned SPACE_W = 16
) (
  input  logic [ALIAS_W-1:0]        low_addr,
  input  logic [ADDR_W-SPACE_W-1:0] high_addr,
  output logic                      legacy_hit,
  output logic                      palette_hit
);
  localparam int unsigned N_RANGES = 2;
  localparam int unsigned N_PAL    = 3;
  localparam logic [N_RANGES-1:0][ALIAS_W-1:0] RNG_LO = {ALIAS_W'(12'h3C0), ALIAS_W'(12'h3B0)};
  localparam logic [N_RANGES-1:0][ALIAS_W-1:0] RNG_HI = {ALIAS_W'(12'h3DF), ALIAS_W'(12'h3BB)};
  localparam logic [N_PAL-1:0][ALIAS_W-1:0]    PAL_AD = {ALIAS_W'(12'h3C9), ALIAS_W'(12'h3C8), ALIAS_W'(12'h3C6)};

  logic [N_RANGES-1:0] rng_hit;
  logic [N_PAL-1:0]    pal_hit;
  logic                space_ok;

  for (genvar gi = 0; gi < N_RANGES; gi++) begin : g_rng
    assign rng_hit[gi] = (low_addr >= RNG_LO[gi]) && (low_addr <= RNG_HI[gi]);
  end

  for (genvar gp = 0; gp < N_PAL; gp++) begin : g_pal
    assign pal_hit[gp] = (low_addr == PAL_AD[gp]);
  end

  always_comb begin
    space_ok    = (high_addr == '0);
    legacy_hit  = space_ok & (|rng_hit);
    palette_hit = space_ok & (|pal_hit);
  end
endmodule

// File: rtl/vga_fwd_policy.sv
module vga_fwd_policy
  import vga_fwd_pkg::*;
(
  input  logic          [1:0] cmd,
  input  logic                mem_hit,
  input  logic                legacy_hit,
  input  logic                palette_hit,
  input  logic                vga_en,
  input  logic                snoop_en,
  output vga_decision_t       decision
);
  logic io_cmd;
  logic mem_take;
  logic io_take;
  logic snoop_take;

  always_comb begin
    io_cmd     = is_io_cmd(cmd);
    mem_take   = !io_cmd && vga_en && mem_hit;
    io_take    = io_cmd && vga_en && legacy_hit;
    // snoop only acts when display-enable is clear; enable wins otherwise
    snoop_take = (cmd == CMD_IO_WR) && snoop_en && !vga_en && palette_hit;
    decision.fwd    = mem_take | io_take | snoop_take;
    decision.single = mem_take && (cmd == CMD_MEM_RD);
  end
endmodule

// File: rtl/vga_fwd_decoder.sv
module vga_fwd_decoder
  import vga_fwd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned BE_W    = 4,
  parameter int unsigned ALIAS_W = 10,
  parameter int unsigned SPACE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  input  logic [1:0]        txn_cmd,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [BE_W-1:0]   txn_be,
  input  logic              vga_en,
  input  logic              snoop_en,
  output logic              fwd_o,
  output logic              claim_o,
  output logic              single_o,
  output logic [BE_W-1:0]   be_o
);
  localparam int unsigned HI_W = ADDR_W - SPACE_W;

  logic          mem_hit;
  logic          legacy_hit;
  logic          palette_hit;
  vga_decision_t decision;

  logic            fwd_d,    fwd_q;
  logic            single_d, single_q;
  logic [BE_W-1:0] be_d,     be_q;
  logic            load_en;

  vga_mem_match #(.ADDR_W(ADDR_W)) u_mem (
    .addr (txn_addr),
    .hit  (mem_hit)
  );

  vga_io_match #(.ADDR_W(ADDR_W), .ALIAS_W(ALIAS_W), .SPACE_W(SPACE_W)) u_io (
    .low_addr    (txn_addr[ALIAS_W-1:0]),
    .high_addr   (txn_addr[ADDR_W-1 -: HI_W]),
    .legacy_hit  (legacy_hit),
    .palette_hit (palette_hit)
  );

  vga_fwd_policy u_pol (
    .cmd         (txn_cmd),
    .mem_hit     (mem_hit),
    .legacy_hit  (legacy_hit),
    .palette_hit (palette_hit),
    .vga_en      (vga_en),
    .snoop_en    (snoop_en),
    .decision    (decision)
  );

  // next state: a strobe loads the decision; an idle cycle clears a held result
  always_comb begin
    load_en  = txn_valid | fwd_q | single_q;
    fwd_d    = txn_valid & decision.fwd;
    single_d = txn_valid & decision.single;
    be_d     = (txn_valid & decision.fwd) ? txn_be : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q    <= 1'b0;
      single_q <= 1'b0;
      be_q     <= '0;
    end else if (load_en) begin
      fwd_q    <= fwd_d;
      single_q <= single_d;
      be_q     <= be_d;
    end
  end

  assign fwd_o    = fwd_q;
  assign claim_o  = fwd_q;
  assign single_o = single_q;
  assign be_o     = be_q;
endmodule

// File: rtl/vga_fwd_checker.sv
module vga_fwd_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_valid,
  input logic [1:0]        txn_cmd,
  input logic [ADDR_W-1:0] txn_addr,
  input logic [BE_W-1:0]   txn_be,
  input logic              vga_en,
  input logic              snoop_en,
  input logic              fwd_o,
  input logic              claim_o,
  input logic              single_o,
  input logic [BE_W-1:0]   be_o
);
  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!fwd_o && !claim_o && !single_o && be_o == '0); // R1
    end
  end

  AST_SINGLE_ONLY_MEMRD: assert property (@(posedge clk) disable iff (!rst_n)
    single_o |-> (fwd_o && $past(txn_cmd) == 2'b00)); // R3

  AST_BE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_o |-> (be_o == $past(txn_be))); // R3

  AST_BE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_o |-> (be_o == '0)); // R3

  AST_IO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_o && $past(txn_cmd[1])) |-> ($past(txn_addr[ADDR_W-1:16]) == '0)); // R6

  AST_SNOOP_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_o && !$past(vga_en)) |-> ($past(txn_cmd) == 2'b11)); // R7

  AST_CLAIM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    claim_o == fwd_o); // R7

  AST_NEED_CONTROL: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_o |-> ($past(vga_en) || $past(snoop_en))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(txn_valid) |-> (!fwd_o && !single_o)); // R11
endmodule

bind vga_fwd_decoder vga_fwd_checker #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (.*);

// File: tb/tb_vga_fwd_decoder.sv
module tb_vga_fwd_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        txn_valid;
  logic [1:0]  txn_cmd;
  logic [31:0] txn_addr;
  logic [3:0]  txn_be;
  logic        vga_en;
  logic        snoop_en;
  logic        fwd_o, claim_o, single_o;
  logic [3:0]  be_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  vga_fwd_decoder dut (.*);

  function automatic bit exp_fwd(input logic [1:0] c, input logic [31:0] a,
                                 input logic ve, input logic se);
    logic [9:0] lo;
    bit up0, leg, pal;
    lo  = a[9:0];
    up0 = (a[31:16] == 16'h0);
    leg = (lo >= 10'h3B0 && lo <= 10'h3BB) || (lo >= 10'h3C0 && lo <= 10'h3DF);
    pal = (lo == 10'h3C6) || (lo == 10'h3C8) || (lo == 10'h3C9);
    if (!c[1]) return ve && a >= 32'h000A_0000 && a <= 32'h000B_FFFF;
    if (ve) return up0 && leg;
    return se && c == 2'b11 && up0 && pal;
  endfunction

  task automatic report(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [31:0] a, input logic [3:0] be,
                       input logic ve, input logic se, input string tag);
    bit f;
    @(negedge clk);
    txn_valid = 1'b1; txn_cmd = c; txn_addr = a; txn_be = be; vga_en = ve; snoop_en = se;
    f = exp_fwd(c, a, ve, se);
    @(negedge clk);
    txn_valid = 1'b0;
    report(tag, "fwd", {31'b0, fwd_o}, {31'b0, f});
    report(tag, "claim", {31'b0, claim_o}, {31'b0, f});
    report(tag, "single", {31'b0, single_o}, {31'b0, f && c == 2'b00});
    report(tag, "be", {28'b0, be_o}, {28'b0, f ? be : 4'h0});
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    report(tag, "idle fwd", {31'b0, fwd_o}, 32'h0);
    report(tag, "idle single", {31'b0, single_o}, 32'h0);
    report(tag, "idle be", {28'b0, be_o}, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1;
        errors++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    bit ve, se;
    logic [1:0] c;
    logic [31:0] a;
    int unsigned seed;
    rst_n = 1'b0; txn_valid = 1'b0; txn_cmd = 2'b00; txn_addr = '0; txn_be = '0;
    vga_en = 1'b0; snoop_en = 1'b0;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    // R1: reset state, even with a strobed hit pending
    txn_valid = 1'b1; vga_en = 1'b1; txn_addr = 32'h000A_0000;
    @(negedge clk);
    report("R1", "fwd", {31'b0, fwd_o}, 32'h0);
    report("R1", "be", {28'b0, be_o}, 32'h0);
    txn_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2 memory window edges and BIOS area
    apply(2'b01, 32'h000A_0000, 4'hF, 1, 0, "R2");
    apply(2'b01, 32'h000B_FFFF, 4'h3, 1, 0, "R2");
    apply(2'b01, 32'h0009_FFFF, 4'hF, 1, 0, "R2");
    apply(2'b00, 32'h000C_0000, 4'hF, 1, 0, "R2");
    // R3 single-phase read and byte enables
    apply(2'b00, 32'h000A_8000, 4'h5, 1, 0, "R3");
    apply(2'b00, 32'h000B_0004, 4'hA, 1, 0, "R3");
    // R4 I/O edges
    apply(2'b10, 32'h0000_03B0, 4'h1, 1, 0, "R4");
    apply(2'b11, 32'h0000_03BB, 4'h2, 1, 0, "R4");
    apply(2'b11, 32'h0000_03AF, 4'h2, 1, 0, "R4");
    apply(2'b11, 32'h0000_03BC, 4'h2, 1, 0, "R4");
    apply(2'b10, 32'h0000_03BF, 4'h2, 1, 0, "R4");
    apply(2'b10, 32'h0000_03C0, 4'h4, 1, 0, "R4");
    apply(2'b11, 32'h0000_03DF, 4'h8, 1, 0, "R4");
    apply(2'b11, 32'h0000_03E0, 4'h8, 1, 0, "R4");
    // R5 alias bits
    for (int k = 0; k < 64; k++) apply(2'b11, {16'h0, k[5:0], 10'h3D4}, 4'h1, 1, 0, "R5");
    // R6 upper bits
    for (int b = 16; b < 32; b++) apply(2'b10, 32'h0000_03C0 | (32'h1 << b), 4'h1, 1, 0, "R6");
    apply(2'b11, 32'h0001_03C8, 4'h1, 0, 1, "R6");
    // R7 snoop-only
    apply(2'b11, 32'h0000_03C6, 4'h1, 0, 1, "R7");
    apply(2'b11, 32'h0000_7BC8, 4'h1, 0, 1, "R7");
    apply(2'b11, 32'h0000_03C9, 4'h1, 0, 1, "R7");
    apply(2'b11, 32'h0000_03C7, 4'h1, 0, 1, "R7");
    apply(2'b10, 32'h0000_03C8, 4'h1, 0, 1, "R7");
    apply(2'b01, 32'h000A_0000, 4'h1, 0, 1, "R7");
    // R8 both set
    apply(2'b10, 32'h0000_03C8, 4'h1, 1, 1, "R8");
    apply(2'b11, 32'h0000_03B4, 4'h1, 1, 1, "R8");
    apply(2'b00, 32'h000B_1000, 4'h6, 1, 1, "R8");
    // R9 neither
    apply(2'b11, 32'h0000_03C8, 4'h1, 0, 0, "R9");
    apply(2'b01, 32'h000A_0000, 4'h1, 0, 0, "R9");
    // R10 command segregation
    apply(2'b00, 32'h0000_03C0, 4'h1, 1, 0, "R10");
    apply(2'b11, 32'h000A_03C0, 4'h1, 1, 0, "R10");
    apply(2'b10, 32'h000B_03B0, 4'h1, 1, 0, "R10");
    // R11 idle clears
    apply(2'b01, 32'h000A_0010, 4'hF, 1, 0, "R11");
    idle_check("R11");

    // random mix
    for (int i = 0; i < 2000; i++) begin
      c  = 2'($urandom);
      ve = 1'($urandom);
      se = 1'($urandom);
      case ($urandom % 4)
        0: a = $urandom;
        1: a = {16'h0, 6'($urandom), 10'h3A0 + 10'($urandom % 96)};
        2: a = 32'h0009_0000 + ($urandom % 32'h0004_0000);
        default: a = {16'($urandom % 3), 6'($urandom), 10'h3C0 + 10'($urandom % 16)};
      endcase
      apply(c, a, 4'($urandom), ve, se, "R2-R10 random");
    end
    idle_check("R11");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule